// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the software-facing control layer placed ahead of a hash engine. Software reaches it through a 32-bit, word-aligned register bus with separate read and write strobes. The block holds a configuration, an interrupt enable, a completion flag and eight digest words. It runs a small phase machine through idle, message-accepting, draining and computing phases. Message words written by software are queued and handed to the engine over a valid/ready stream. The engine reports completion with a one-cycle pulse and a 256-bit result, which the block latches for software to read.

The register bus is combinational on reads. `reg_rdata` reflects `reg_addr` in the same cycle that `reg_rd` is high, and is zero otherwise. Writes take effect at the clock edge where `reg_wr` is high.

Stream rules for back-pressure on the message output:
- A word transfers on a rising edge where `msg_valid` and `msg_ready` are both high.
- While `msg_valid` is high and `msg_ready` is low, `msg_data` holds steady.
- The queue has no bus wait state, so software paces its writes. A message write that arrives while the queue is full is dropped.

Top module: `hash_ctl_front`

## Requirements
- R1: The configuration register at byte offset 0x00 keeps write-data bits [3:0] and reads them back in bits [3:0]. The bits are: bit 0 keyed-hash mode, bit 1 engine enable, bit 2 input byte swap, bit 3 digest byte swap.
- R2: A configuration write changes the register only while the block is idle. In any other phase the write is discarded.
- R3: The interrupt-enable register at 0x04 stores the written value ANDed with 7. `irq` is high exactly when the completion flag and enable bit 0 are both set.
- R4: The completion flag is bit 0 of the register at 0x08. Writing 1 there clears it; writing 0 leaves it unchanged.
- R5: A start command (a write to 0x0C with bit 0 set) leaves idle for the message phase and pulses `eng_start` one cycle later. It does so only when all of these hold: the configuration equals 0x6 (engine on, input swap on, keyed mode off, digest swap off), the interrupt enable is 0, and the completion flag is clear. Otherwise nothing happens.
- R6: In the message phase, each write to 0x10 queues one word, and the words leave on the stream in write order. Byte 0 of the message is bits [7:0]. A word stays on `msg_data` while it is not accepted. A write made while the queue holds `FIFO_DEPTH` words is dropped.
- R7: A process command (a write to 0x0C with bit 1 set) in the message phase moves the block to draining. Once the queue is empty, the block pulses `eng_process` and enters the computing phase.
- R8: An `eng_done` pulse in the computing phase returns the block to idle, sets the completion flag, and latches digest word i as `eng_digest[32*i+31:32*i]`.
- R9: Digest word i (0 to 7) is read at byte address 0x30 - 4*i.
- R10: Reads of unaligned, out-of-window (0x34 and above) and write-only addresses (0x0C, 0x10) return 0. Writes to unmapped addresses, message writes outside the message phase, and commands issued in the wrong phase have no effect.
- R11: If an `eng_done` pulse and a write-1-to-clear of the flag land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, same cycle |
| msg_valid | output | 1 | Message word available |
| msg_ready | input | 1 | Engine accepts message word |
| msg_data | output | 32 | Message word, byte 0 in bits [7:0] |
| eng_start | output | 1 | One-cycle pulse: new hash begins |
| eng_process | output | 1 | One-cycle pulse: message complete, compute |
| eng_done | input | 1 | One-cycle pulse: computation finished |
| eng_digest | input | 256 | Engine result, word i in bits [32*i+31:32*i] |
| irq | output | 1 | Completion interrupt |

## Verification
The main sequence is driven with several kinds of stimulus:
- Start commands under three rejecting configurations and one accepting configuration. This separates the exact-match gate from a looser check of the enable bit alone.
- Message streams under two patterns: an irregular ready pattern, and ready held low until the queue overflows. The first checks ordering under back-pressure; the second checks the drop-on-full boundary.
- Two completions. One is driven by a delayed stub engine. The other is forced in the same cycle as a flag-clear write, which exposes the set-over-clear priority.
- Digest reads at every slot. These tell the reversed address order apart from a forward one.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;
  localparam int DW        = 32;
  localparam int CFG_BITS  = 4;
  localparam int IEN_BITS  = 3;
  localparam int NDIG      = 8;
  localparam int DIGEST_W  = DW * NDIG;

  localparam logic [CFG_BITS-1:0] CFG_REQUIRED = 4'b0110;

  // word indices inside the window
  localparam int IDX_CFG    = 0;
  localparam int IDX_IEN    = 1;
  localparam int IDX_ISTATE = 2;
  localparam int IDX_CMD    = 3;
  localparam int IDX_MSG    = 4;
  localparam int IDX_DIG0   = 5;
  localparam int NUM_WORDS  = IDX_DIG0 + NDIG;

  localparam int CMD_START_BIT   = 0;
  localparam int CMD_PROCESS_BIT = 1;
  localparam int DONE_BIT        = 0;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CONSUME = 2'd1,
    PH_DRAIN   = 2'd2,
    PH_PROCESS = 2'd3
  } phase_e;
endpackage

// File: rtl/hcf_msg_fifo.sv
module hcf_msg_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end
endmodule

// File: rtl/hcf_seq.sv
module hcf_seq
  import hash_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_start,
  input  logic   cmd_proc,
  input  logic   start_ok,
  input  logic   queue_empty,
  input  logic   eng_done,
  output phase_e phase,
  output logic   done_set,
  output logic   eng_start,
  output logic   eng_process
);
  phase_e ph_q, ph_d;
  logic   go_start, go_proc;

  assign go_start = (ph_q == PH_IDLE) && cmd_start && start_ok;
  assign go_proc  = (ph_q == PH_DRAIN) && queue_empty;
  assign done_set = (ph_q == PH_PROCESS) && eng_done;
  assign phase    = ph_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:    if (go_start) ph_d = PH_CONSUME;
      PH_CONSUME: if (cmd_proc) ph_d = PH_DRAIN;
      PH_DRAIN:   if (go_proc)  ph_d = PH_PROCESS;
      PH_PROCESS: if (eng_done) ph_d = PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      eng_start   <= 1'b0;
      eng_process <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      eng_start   <= go_start;
      eng_process <= go_proc;
    end
  end
endmodule

// File: rtl/hcf_csr.sv
module hcf_csr
  import hash_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle,
  input  logic                wr_cfg,
  input  logic                wr_ien,
  input  logic                wr_istate,
  input  logic [CFG_BITS-1:0] wdata_lo,
  input  logic                done_set,
  input  logic [DIGEST_W-1:0] digest_in,
  input  logic                rd_en,
  input  logic [31:0]         rd_idx,
  output logic [CFG_BITS-1:0] cfg,
  output logic [IEN_BITS-1:0] ien,
  output logic                done,
  output logic [DW-1:0]       rdata
);
  localparam int SW = $clog2(NDIG);

  logic [DW-1:0] dig_q [NDIG];
  logic [SW-1:0] slot, word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      ien  <= '0;
      done <= 1'b0;
    end else begin
      if (wr_cfg && idle) cfg <= wdata_lo;
      if (wr_ien)         ien <= wdata_lo[IEN_BITS-1:0];
      if (done_set)       done <= 1'b1;
      else if (wr_istate && wdata_lo[DONE_BIT]) done <= 1'b0;
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dig_q[g] <= '0;
      else if (done_set) dig_q[g] <= digest_in[g*DW +: DW];
    end
  end

  assign slot   = SW'(rd_idx - 32'(IDX_DIG0));
  assign word_i = SW'(NDIG - 1) - slot;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (rd_idx == 32'(IDX_CFG))
        rdata = DW'(cfg);
      else if (rd_idx == 32'(IDX_IEN))
        rdata = DW'(ien);
      else if (rd_idx == 32'(IDX_ISTATE))
        rdata = DW'(done) << DONE_BIT;
      else if (rd_idx >= 32'(IDX_DIG0) && rd_idx < 32'(IDX_DIG0 + NDIG))
        rdata = dig_q[word_i];
    end
  end
endmodule

// File: rtl/hash_ctl_front.sv
module hash_ctl_front
  import hash_ctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DW-1:0]       reg_wdata,
  input  logic                reg_rd,
  output logic [DW-1:0]       reg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [DW-1:0]       msg_data,
  output logic                eng_start,
  output logic                eng_process,
  input  logic                eng_done,
  input  logic [DIGEST_W-1:0] eng_digest,
  output logic                irq
);
  logic [31:0]         widx;
  logic                hit;
  logic                wr_cfg, wr_ien, wr_istate, wr_cmd, wr_msg;
  logic                cmd_start, cmd_proc, start_ok;
  logic                q_empty, q_full, q_push;
  logic                done_set, done;
  logic [CFG_BITS-1:0] cfg;
  logic [IEN_BITS-1:0] ien;
  phase_e              phase;

  // address decode: aligned words inside the window only
  assign widx      = 32'(reg_addr[ADDR_W-1:2]);
  assign hit       = (reg_addr[1:0] == 2'b00) && (widx < 32'(NUM_WORDS));
  assign wr_cfg    = reg_wr && hit && (widx == 32'(IDX_CFG));
  assign wr_ien    = reg_wr && hit && (widx == 32'(IDX_IEN));
  assign wr_istate = reg_wr && hit && (widx == 32'(IDX_ISTATE));
  assign wr_cmd    = reg_wr && hit && (widx == 32'(IDX_CMD));
  assign wr_msg    = reg_wr && hit && (widx == 32'(IDX_MSG));

  assign cmd_start = wr_cmd && reg_wdata[CMD_START_BIT];
  assign cmd_proc  = wr_cmd && reg_wdata[CMD_PROCESS_BIT];
  assign start_ok  = (cfg == CFG_REQUIRED) && (ien == '0) && !done;
  assign q_push    = wr_msg && (phase == PH_CONSUME);
  assign msg_valid = !q_empty;
  assign irq       = done && ien[0];

  hcf_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_proc    (cmd_proc),
    .start_ok    (start_ok),
    .queue_empty (q_empty),
    .eng_done    (eng_done),
    .phase       (phase),
    .done_set    (done_set),
    .eng_start   (eng_start),
    .eng_process (eng_process)
  );

  hcf_msg_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (reg_wdata),
    .pop   (msg_ready),
    .dout  (msg_data),
    .empty (q_empty),
    .full  (q_full)
  );

  hcf_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (phase == PH_IDLE),
    .wr_cfg    (wr_cfg),
    .wr_ien    (wr_ien),
    .wr_istate (wr_istate),
    .wdata_lo  (reg_wdata[CFG_BITS-1:0]),
    .done_set  (done_set),
    .digest_in (eng_digest),
    .rd_en     (reg_rd && hit),
    .rd_idx    (widx),
    .cfg       (cfg),
    .ien       (ien),
    .done      (done),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/hash_ctl_front_chk.sv
module hash_ctl_front_chk
  import hash_ctl_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input phase_e              phase,
  input logic [CFG_BITS-1:0] cfg,
  input logic                done,
  input logic                done_set,
  input logic                clr_req,
  input logic                cmd_start,
  input logic                start_ok,
  input logic                eng_start,
  input logic                eng_process,
  input logic                q_empty,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [DW-1:0]       msg_data
);
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(cfg)); // R2

  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !done_set) |=> !done); // R4

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && cmd_start && !start_ok) |=> (!eng_start && phase == PH_IDLE)); // R5

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data))); // R6

  AST_PROC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_process |-> (q_empty && phase == PH_PROCESS)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> (done && phase == PH_IDLE)); // R11
endmodule

bind hash_ctl_front hash_ctl_front_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase       (phase),
  .cfg         (cfg),
  .done        (done),
  .done_set    (done_set),
  .clr_req     (wr_istate && reg_wdata[0]),
  .cmd_start   (cmd_start),
  .start_ok    (start_ok),
  .eng_start   (eng_start),
  .eng_process (eng_process),
  .q_empty     (q_empty),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_data    (msg_data)
);

// File: tb/hash_ctl_front_tb_top.sv
module hash_ctl_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DEPTH      = 4;
  localparam int STUB_DELAY = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic         msg_valid, msg_ready = 1'b0;
  logic [31:0]  msg_data;
  logic         eng_start, eng_process, irq;
  logic         stub_done = 1'b0, man_done = 1'b0;
  logic [255:0] eng_digest;

  int n_chk = 0, n_err = 0;
  int start_cnt = 0, proc_cnt = 0, cyc = 0;
  logic hold_ready = 1'b0, manual = 1'b0;
  logic [31:0] stub_acc = '0, stub_n = '0, sent_acc = '0, sent_n = '0;
  logic stub_busy = 1'b0;
  int   stub_wait = 0;
  logic [31:0] exp_q[$];
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_ctl_front #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .eng_start(eng_start), .eng_process(eng_process),
    .eng_done(stub_done | man_done), .eng_digest(eng_digest), .irq(irq));

  function automatic logic [31:0] dig_word(int i, logic [31:0] acc, logic [31:0] n);
    return (acc ^ (32'h1000_0001 * 32'(i + 1))) + n;
  endfunction

  always_comb
    for (int i = 0; i < 8; i++) eng_digest[i*32 +: 32] = dig_word(i, stub_acc, stub_n);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: records an expected stream word unless the queue would drop it
  task automatic send_word(logic [31:0] w, bit expect_keep);
    if (expect_keep) begin
      exp_q.push_back(w);
      sent_acc ^= w;
      sent_n++;
    end
    bus_wr(8'h10, w);
  endtask

  // stub engine and ready pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    msg_ready <= hold_ready ? 1'b0 : ((cyc % 3) != 0);
    stub_done <= 1'b0;
    if (eng_start) start_cnt <= start_cnt + 1;
    if (eng_process) proc_cnt <= proc_cnt + 1;
    if (eng_start) begin
      stub_acc <= '0; stub_n <= '0;
    end else if (msg_valid && msg_ready) begin
      stub_acc <= stub_acc ^ msg_data; stub_n <= stub_n + 1;
    end
    if (eng_process) begin
      stub_busy <= 1'b1; stub_wait <= STUB_DELAY;
    end else if (stub_busy && !manual) begin
      if (stub_wait == 0) begin stub_done <= 1'b1; stub_busy <= 1'b0; end
      else stub_wait <= stub_wait - 1;
    end
  end

  // monitor: scoreboard for the message stream (R6)
  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) check("R6 unexpected word", msg_data, 32'hxxxx_xxxx);
      else check("R6 stream order", msg_data, exp_q.pop_front());
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    bus_rd(8'h00, rv); check("R1 reset cfg", rv, 0);
    bus_rd(8'h08, rv); check("R4 reset flag", rv, 0);
    bus_rd(8'h30, rv); check("R9 reset digest", rv, 0);
    check("R6 reset valid", 32'(msg_valid), 0);
    check("R3 reset irq", 32'(irq), 0);

    bus_wr(8'h00, 32'hFFFF_FFF6); bus_rd(8'h00, rv); check("R1 cfg keeps 4 bits", rv, 32'h6);
    bus_wr(8'h04, 32'hFF);        bus_rd(8'h04, rv); check("R3 ien masked", rv, 32'h7);

    bus_wr(8'h0C, 32'h1); wait_cyc(3); check("R5 start rejected ien set", 32'(start_cnt), 0);
    bus_wr(8'h04, 32'h0); bus_wr(8'h00, 32'h7);
    bus_wr(8'h0C, 32'h1); wait_cyc(3); check("R5 start rejected keyed mode", 32'(start_cnt), 0);
    bus_wr(8'h00, 32'h6);
    bus_wr(8'h0C, 32'h2); wait_cyc(3); check("R10 process in idle ignored", 32'(proc_cnt), 0);
    bus_wr(8'h10, 32'hDEAD); wait_cyc(2); check("R10 msg in idle ignored", 32'(msg_valid), 0);

    bus_wr(8'h0C, 32'h1); wait_cyc(3); check("R5 start accepted", 32'(start_cnt), 1);
    bus_wr(8'h00, 32'h0); bus_rd(8'h00, rv); check("R2 cfg frozen while busy", rv, 32'h6);

    sent_acc = '0; sent_n = '0;
    send_word(32'h0403_0201, 1'b1);
    send_word(32'hA5A5_5A5A, 1'b1);
    bus_wr(8'h0C, 32'h1); wait_cyc(2); check("R10 start in message phase", 32'(start_cnt), 1);
    send_word(32'h1234_5678, 1'b1);
    bus_wr(8'h0C, 32'h2);
    for (int i = 0; i < 50 && proc_cnt == 0; i++) wait_cyc(1);
    check("R7 process pulse", 32'(proc_cnt), 1);
    check("R6 all words streamed", 32'(exp_q.size()), 0);
    wait_cyc(STUB_DELAY + 4);
    bus_rd(8'h08, rv); check("R8 flag set on done", rv, 1);
    check("R3 irq off with ien 0", 32'(irq), 0);
    for (int i = 0; i < 8; i++) begin
      bus_rd(8'(8'h30 - 4*i), rv);
      check($sformatf("R9 digest word %0d", i), rv, dig_word(i, sent_acc, sent_n));
    end

    bus_rd(8'h31, rv); check("R10 unaligned read", rv, 0);
    bus_rd(8'h10, rv); check("R10 write-only read", rv, 0);
    bus_rd(8'h34, rv); check("R10 out of window read", rv, 0);
    bus_wr(8'h34, 32'h0); bus_wr(8'h01, 32'h0); bus_wr(8'h09, 32'h1);
    bus_rd(8'h00, rv); check("R10 stray writes cfg", rv, 32'h6);
    bus_rd(8'h08, rv); check("R10 stray writes flag", rv, 1);

    bus_wr(8'h04, 32'h1); wait_cyc(1); check("R3 irq on", 32'(irq), 1);
    bus_wr(8'h04, 32'h0);
    bus_wr(8'h0C, 32'h1); wait_cyc(3); check("R5 start rejected flag set", 32'(start_cnt), 1);
    bus_wr(8'h08, 32'h0); bus_rd(8'h08, rv); check("R4 write 0 keeps flag", rv, 1);
    bus_wr(8'h08, 32'h1); bus_rd(8'h08, rv); check("R4 write 1 clears flag", rv, 0);

    // second hash: queue overflow, then forced done against a clear
    hold_ready = 1'b1; manual = 1'b1;
    bus_wr(8'h0C, 32'h1); wait_cyc(3); check("R5 second start", 32'(start_cnt), 2);
    sent_acc = '0; sent_n = '0;
    for (int i = 0; i < DEPTH; i++) send_word(32'hC000_0000 + 32'(i), 1'b1);
    send_word(32'hBAD0_BAD0, 1'b0);
    check("R6 held word", msg_data, 32'hC000_0000);
    hold_ready = 1'b0;
    bus_wr(8'h0C, 32'h2);
    for (int i = 0; i < 50 && proc_cnt < 2; i++) wait_cyc(1);
    check("R7 second process pulse", 32'(proc_cnt), 2);
    check("R6 overflow word dropped", 32'(exp_q.size()), 0);
    @(negedge clk);
    man_done = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk);
    man_done = 1'b0; reg_wr = 1'b0;
    bus_rd(8'h08, rv); check("R11 set wins over clear", rv, 1);
    bus_rd(8'h30, rv); check("R8 digest latched", rv, dig_word(0, sent_acc, sent_n));
    bus_rd(8'h14, rv); check("R9 last slot", rv, dig_word(7, sent_acc, sent_n));
    summary();
  end
endmodule